// File: doc/BRIEF.md
# Match-Rollover Real-Time Clock Counter

This block keeps wall-clock time from a slow reference of about 32 kHz. It runs on the system clock. It does not use the slow input as a clock. The slow input passes through a two-flop synchronizer and a rising-edge detector, which together give one system-clock-wide advance pulse per slow period. A 32-bit up-counter takes one step on each such pulse.

The counter does not wrap on overflow. It wraps on a programmable compare value. When the count equals that value, the next count is zero and counting carries on. Each wrap sets a sticky raw status flag. A mask bit decides whether the flag also shows as masked status and drives the level interrupt output. Software clears the flag with a write-one-to-clear register.

Turning the counter on always starts it from one. Turning it off freezes the count where it is. The block ignores the debug stall input, so time keeps running while a debugger halts the rest of the chip. Registers are reached through a plain write strobe, a 3-bit address and a combinational read port.

Top module: `rtc_match_counter`

## Requirements
- R1: Writing the control register (address 0) with bit 0 set, while the enable bit is clear, loads the count with 0x00000001. The count reads back at address 2.
- R2: On an advance pulse with the count equal to the compare register (address 1), the next count is 0x00000000. Later pulses keep counting up from zero.
- R3: While the enable bit is clear, the count holds its value. Setting the enable bit again reloads 0x00000001.
- R4: Every wrap sets the raw status flag (address 3, bit 0), whatever the mask holds.
- R5: The masked status (address 5, bit 0) and `irq_o` are high exactly when the raw flag is set and the mask bit (address 4, bit 0) is set.
- R6: Writing 1 to bit 0 of the clear register (address 6) clears the raw and masked flags. Writing 0 there changes nothing.
- R7: Asserting `dbg_stall_i` does not stop or slow the count.
- R8: The count advances once per rising edge of `slow_clk_i`, however long the input stays high.
- R9: When a wrap and a clear write happen in the same cycle, the raw flag ends up set.
- R10: After reset the control register, count, raw flag and mask read 0, the compare register reads 0xFFFFFFFF, and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low reset; the release is synchronized inside the block |
| slow_clk_i | input | 1 | 32 kHz reference, asynchronous to `clk` |
| dbg_stall_i | input | 1 | Debug halt request; has no effect on this counter |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address for reads and writes |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i`, combinational |
| irq_o | output | 1 | Level interrupt: raw flag AND mask |

## Verification
The hardest case to reach is a clear write that lands in the same system cycle as a wrap. From the ports, that cycle is fixed only by the latency of the synchronizer and edge detector. The bench sets the count equal to the compare value and drives a slow rising edge just before a known clock edge. It then places the clear write exactly two edges later, which is the cycle in which the advance pulse is live. After that it checks that the raw flag is still set and that the count has wrapped to zero.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_CTRL  = 3'd0,
    RA_CMP   = 3'd1,
    RA_COUNT = 3'd2,
    RA_RAW   = 3'd3,
    RA_MASK  = 3'd4,
    RA_MSTAT = 3'd5,
    RA_CLEAR = 3'd6
  } rtc_addr_e;
endpackage

// File: rtl/rtc_rst_sync.sv
module rtc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/rtc_tick_gen.sv
module rtc_tick_gen #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic tick_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= async_i;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sync_q[SYNC_STAGES-1];
  end

  assign tick_o = sync_q[SYNC_STAGES-1] & ~prev_q;
endmodule

// File: rtl/rtc_count_core.sv
module rtc_count_core #(
  parameter int W            = 32,
  parameter bit STALL_FREEZE = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         stall_i,
  input  logic         en_i,
  input  logic         load_i,
  input  logic [W-1:0] cmp_i,
  output logic [W-1:0] count_o,
  output logic         hit_o
);
  localparam logic [W-1:0] START = W'(1);

  logic [W-1:0] count_q, count_d;
  logic         step;
  logic         run_ok;

  generate
    if (STALL_FREEZE) begin : g_stall
      assign run_ok = ~stall_i;
    end else begin : g_free
      assign run_ok = 1'b1 | stall_i;
    end
  endgenerate

  assign step = en_i & tick_i & run_ok;

  always_comb begin
    count_d = count_q;
    hit_o   = 1'b0;
    if (load_i) begin
      count_d = START;
    end else if (step) begin
      if (count_q == cmp_i) begin
        count_d = '0;
        hit_o   = 1'b1;
      end else begin
        count_d = count_q + START;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                count_q <= '0;
    else if (load_i || step)   count_q <= count_d;
  end

  assign count_o = count_q;
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  input  logic mask_i,
  output logic raw_o,
  output logic masked_o
);
  logic raw_q, raw_d;

  always_comb begin
    raw_d = raw_q;
    if (hit_i)      raw_d = 1'b1;
    else if (clr_i) raw_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              raw_q <= 1'b0;
    else if (hit_i || clr_i) raw_q <= raw_d;
  end

  assign raw_o    = raw_q;
  assign masked_o = raw_q & mask_i;
endmodule

// File: rtl/rtc_match_counter.sv
module rtc_match_counter
  import rtc_pkg::*;
#(
  parameter int W           = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              slow_clk_i,
  input  logic              dbg_stall_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [W-1:0]      reg_wdata_i,
  output logic [W-1:0]      reg_rdata_o,
  output logic              irq_o
);
  logic         rst_n;
  logic         tick;
  logic         hit;
  logic         raw;
  logic         masked;
  logic [W-1:0] count;

  logic         en_q, en_d;
  logic         mask_q, mask_d;
  logic [W-1:0] cmp_q, cmp_d;
  logic         wr_ctrl, wr_cmp, wr_mask, wr_clr;
  logic         en_load;

  rtc_rst_sync #(.STAGES(2)) u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  rtc_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (slow_clk_i),
    .tick_o  (tick)
  );

  assign wr_ctrl = reg_we_i && (reg_addr_i == RA_CTRL);
  assign wr_cmp  = reg_we_i && (reg_addr_i == RA_CMP);
  assign wr_mask = reg_we_i && (reg_addr_i == RA_MASK);
  assign wr_clr  = reg_we_i && (reg_addr_i == RA_CLEAR) && reg_wdata_i[0];
  assign en_load = wr_ctrl && reg_wdata_i[0] && !en_q;

  always_comb begin
    en_d   = wr_ctrl ? reg_wdata_i[0] : en_q;
    mask_d = wr_mask ? reg_wdata_i[0] : mask_q;
    cmp_d  = wr_cmp  ? reg_wdata_i    : cmp_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mask_q <= 1'b0;
      cmp_q  <= '1;
    end else begin
      if (wr_ctrl) en_q   <= en_d;
      if (wr_mask) mask_q <= mask_d;
      if (wr_cmp)  cmp_q  <= cmp_d;
    end
  end

  rtc_count_core #(.W(W), .STALL_FREEZE(1'b0)) u_core (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_i  (tick),
    .stall_i (dbg_stall_i),
    .en_i    (en_q),
    .load_i  (en_load),
    .cmp_i   (cmp_q),
    .count_o (count),
    .hit_o   (hit)
  );

  rtc_irq_ctrl u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .clr_i    (wr_clr),
    .mask_i   (mask_q),
    .raw_o    (raw),
    .masked_o (masked)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      RA_CTRL:  reg_rdata_o[0] = en_q;
      RA_CMP:   reg_rdata_o    = cmp_q;
      RA_COUNT: reg_rdata_o    = count;
      RA_RAW:   reg_rdata_o[0] = raw;
      RA_MASK:  reg_rdata_o[0] = mask_q;
      RA_MSTAT: reg_rdata_o[0] = masked;
      default:  reg_rdata_o    = '0;
    endcase
  end

  assign irq_o = masked;
endmodule

// File: rtl/rtc_match_counter_chk.sv
module rtc_match_counter_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         en,
  input logic         en_load,
  input logic         stall,
  input logic         hit,
  input logic [W-1:0] count,
  input logic [W-1:0] cmp,
  input logic         raw,
  input logic         irq
);
  // R1
  load_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_load |=> count == W'(1));

  // R2
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && tick && count == cmp && !en_load) |=> count == '0);

  // R3
  hold_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !en_load) |=> $stable(count));

  // R4
  raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> raw);

  // R5
  irq_raw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> raw);

  // R7
  stall_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && en && tick && count != cmp && !en_load) |=> count == $past(count) + W'(1));

  // R8
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

bind rtc_match_counter rtc_match_counter_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .tick    (tick),
  .en      (en_q),
  .en_load (en_load),
  .stall   (dbg_stall_i),
  .hit     (hit),
  .count   (count),
  .cmp     (cmp_q),
  .raw     (raw),
  .irq     (irq_o)
);

// File: tb/rtc_match_counter_bench.sv
module rtc_match_counter_bench;
  logic        clk = 1'b0;
  logic        arst_n = 1'b0;
  logic        slow_clk = 1'b0;
  logic        stall = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rtc_match_counter u_rtc_match_counter (
    .clk         (clk),
    .arst_n      (arst_n),
    .slow_clk_i  (slow_clk),
    .dbg_stall_i (stall),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  localparam int NV = 6;
  localparam logic [31:0] V_CMP [NV]   = '{32'd3, 32'd3, 32'd3, 32'd3, 32'd1, 32'd5};
  localparam int          V_PULSE [NV] = '{0, 2, 3, 5, 1, 6};
  localparam logic [31:0] V_CNT [NV]   = '{32'd1, 32'd3, 32'd0, 32'd2, 32'd0, 32'd1};
  localparam logic [31:0] V_RAW [NV]   = '{32'd0, 32'd0, 32'd1, 32'd1, 32'd1, 32'd1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic slow_pulse(input int high_len);
    @(negedge clk);
    slow_clk = 1'b1;
    repeat (high_len) @(negedge clk);
    slow_clk = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R10 reset state
    rd(3'd0, v); check("R10 ctrl", v, 32'd0);
    rd(3'd2, v); check("R10 count", v, 32'd0);
    rd(3'd3, v); check("R10 raw", v, 32'd0);
    rd(3'd4, v); check("R10 mask", v, 32'd0);
    rd(3'd1, v); check("R10 cmp", v, 32'hFFFF_FFFF);
    check("R10 irq", {31'd0, irq}, 32'd0);

    // Vector walk: R1, R2, R4
    for (int i = 0; i < NV; i++) begin
      wr(3'd0, 32'd0);
      wr(3'd6, 32'd1);
      wr(3'd1, V_CMP[i]);
      wr(3'd0, 32'd1);
      for (int p = 0; p < V_PULSE[i]; p++) slow_pulse(4);
      rd(3'd2, v); check("R1/R2 count", v, V_CNT[i]);
      rd(3'd3, v); check("R4 raw", v, V_RAW[i]);
    end

    // R5 mask off: raw set, irq low; then mask on
    rd(3'd5, v); check("R5 mstat masked off", v, 32'd0);
    check("R5 irq masked off", {31'd0, irq}, 32'd0);
    wr(3'd4, 32'd1);
    rd(3'd5, v); check("R5 mstat", v, 32'd1);
    check("R5 irq", {31'd0, irq}, 32'd1);

    // R6 writing 0 to clear has no effect, writing 1 clears
    wr(3'd6, 32'd0);
    rd(3'd3, v); check("R6 clear-0 ignored", v, 32'd1);
    wr(3'd6, 32'd1);
    rd(3'd3, v); check("R6 raw cleared", v, 32'd0);
    rd(3'd5, v); check("R6 mstat cleared", v, 32'd0);
    check("R6 irq cleared", {31'd0, irq}, 32'd0);

    // R3 disable holds, re-enable reloads 1
    wr(3'd1, 32'd100);
    wr(3'd0, 32'd0);
    wr(3'd0, 32'd1);
    slow_pulse(4); slow_pulse(4);
    rd(3'd2, v); check("R3 running", v, 32'd3);
    wr(3'd0, 32'd0);
    slow_pulse(4); slow_pulse(4);
    rd(3'd2, v); check("R3 held", v, 32'd3);
    wr(3'd0, 32'd1);
    rd(3'd2, v); check("R3 reload", v, 32'd1);

    // R7 stall ignored
    stall = 1'b1;
    slow_pulse(4); slow_pulse(4);
    rd(3'd2, v); check("R7 stall", v, 32'd3);
    stall = 1'b0;

    // R8 long high level gives a single step
    slow_pulse(40);
    rd(3'd2, v); check("R8 one step", v, 32'd4);

    // R9 wrap and clear in the same cycle: set wins
    wr(3'd0, 32'd0);
    wr(3'd1, 32'd1);
    wr(3'd0, 32'd1);
    wr(3'd6, 32'd1);
    @(negedge clk);
    slow_clk = 1'b1;
    @(negedge clk);
    @(negedge clk);
    we = 1'b1; addr = 3'd6; wdata = 32'd1;
    @(negedge clk);
    we = 1'b0;
    slow_clk = 1'b0;
    rd(3'd3, v); check("R9 set wins", v, 32'd1);
    rd(3'd2, v); check("R9 wrapped", v, 32'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule